// File: doc/BRIEF.md
# Register Pointer with Auto-Increment and Indexed Storage Window

This block keeps the register address pointer behind a byte-wide serial slave. A transaction begins with a start strobe that carries the register address; after that, each data byte that is read or written moves the pointer on by one. Registers that hold more than one byte, and the two registers that form the storage window, keep the pointer where it is, so a burst aimed at them keeps hitting the same register.

The storage window gives access to a 200-byte general-purpose store through two registers. The index register (0x60) selects a byte. The data-port register (0x61) reads or writes the selected byte and then moves its own index on by one, wrapping after the last entry. A small pending-event register (0x02) holds two event flags. A flag is set by a hardware event pulse and cleared when software writes a 1 to its bit. Every other register is a plain byte of storage.

Top module: `reg_ptr_window`

## Requirements
- R1: A cycle with `txn_start_i` high loads the pointer from `addr_i`, whatever the pointer held before. Read and write strobes in that cycle are ignored.
- R2: After a read or write of a single-byte register, the pointer increases by one and wraps from 0xFF to 0x00. For example, a two-byte write starting at 0x00 stores to 0x00 and then to 0x01.
- R3: When the pointer is at 0x29, 0x2D, 0x4F or 0x7F, reads and writes leave it unchanged. Repeated writes overwrite that register, and the next address is left untouched.
- R4: Register 0x60 holds the pointer. A write stores the storage index, and any value of 200 or more becomes 199. A read returns the index.
- R5: Each read or write of register 0x61 uses the storage byte at the current index and then increases the index by one, wrapping from 199 to 0. The pointer stays at 0x61.
- R6: `rd_data_o` shows the value at the pointer, or for 0x61 the storage byte at the current index, as it stands before the advance that the read causes.
- R7: Register 0x02, bits 1:0: writing 1 to a bit clears that pending flag, and writing 0 leaves it as it is. Bits 7:2 are plain read/write storage.
- R8: A `wdt_evt_i` pulse sets both bit 0 and bit 1 of register 0x02, so it reads 3 with the upper bits at zero. An `rtc_evt_i` pulse sets bit 0 only. If a set and a clearing write fall in the same cycle, the set wins.
- R9: After reset the pointer, the index, the event flags, every register byte and every storage byte are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start_i | input | 1 | Start of transaction; loads the pointer from addr_i |
| addr_i | input | 8 | Register address byte |
| wr_i | input | 1 | Write-byte strobe |
| wr_data_i | input | 8 | Write data byte |
| rd_i | input | 1 | Read-byte strobe (ignored if wr_i is also high) |
| rd_data_o | output | 8 | Read data at the current pointer |
| rtc_evt_i | input | 1 | Clock-defaults event pulse; sets flag bit 0 |
| wdt_evt_i | input | 1 | Watchdog reset event pulse; sets flag bits 0 and 1 |

## Verification
A pointer that steps when it should hold, or holds when it should step, shows on `rd_data_o` at the very next read strobe: that read returns the neighbouring register or the previously written byte instead of the expected one. A storage index that drifts or fails to wrap shows on the next access to 0x61 as the wrong storage byte, and on a read of 0x60 as the wrong index, one cycle after the access that caused it. Event-flag errors show on the first read of 0x02 after the pulse or the clearing write.

// File: rtl/rpw_pkg.sv
package rpw_pkg;
   localparam int unsigned RPW_BYTE_W  = 8;
   localparam int unsigned RPW_NUM_EVT = 2;

   typedef enum logic [1:0] {
      ACC_IDLE  = 2'd0,
      ACC_READ  = 2'd1,
      ACC_WRITE = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/rpw_ptr_ctrl.sv
module rpw_ptr_ctrl #(
   parameter int unsigned AW        = 8,
   parameter int unsigned NUM_HOLD  = 4,
   parameter logic [NUM_HOLD*AW-1:0] HOLD_LIST = {8'h29, 8'h2D, 8'h4F, 8'h7F},
   parameter logic [AW-1:0] IDX_ADDR  = 8'h60,
   parameter logic [AW-1:0] PORT_ADDR = 8'h61
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [AW-1:0] addr_i,
   input  logic          step_i,
   output logic [AW-1:0] ptr_o
);
   if (NUM_HOLD < 1) begin : g_bad_hold
      $error("rpw_ptr_ctrl: NUM_HOLD must be at least 1");
   end

   logic [AW-1:0]       ptr_q;
   logic [NUM_HOLD-1:0] hit;
   logic                hold;

   for (genvar i = 0; i < NUM_HOLD; i++) begin : g_hit
      assign hit[i] = (ptr_q == HOLD_LIST[i*AW +: AW]);
   end

   assign hold = (|hit) || (ptr_q == IDX_ADDR) || (ptr_q == PORT_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                ptr_q <= '0;
      else if (load_i)           ptr_q <= addr_i;
      else if (step_i && !hold)  ptr_q <= ptr_q + 1'b1;
   end

   assign ptr_o = ptr_q;

   assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> ptr_q == $past(addr_i));

   assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !(|hit) && ptr_q != IDX_ADDR && ptr_q != PORT_ADDR)
         |=> ptr_q == $past(ptr_q) + 1'b1);

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && (|hit)) |=> $stable(ptr_q));

   assert_idx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && (ptr_q == IDX_ADDR || ptr_q == PORT_ADDR)) |=> $stable(ptr_q));
endmodule

// File: rtl/rpw_bank_window.sv
module rpw_bank_window #(
   parameter int unsigned DW    = 8,
   parameter int unsigned DEPTH = 200,
   localparam int unsigned IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          idx_wr_i,
   input  logic          port_wr_i,
   input  logic          port_rd_i,
   input  logic [DW-1:0] wdata_i,
   output logic [DW-1:0] idx_o,
   output logic [DW-1:0] port_data_o
);
   if (DEPTH < 2 || IW > DW) begin : g_bad_depth
      $error("rpw_bank_window: DEPTH must be 2..2**DW");
   end

   localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

   logic [DW-1:0] store_q [DEPTH];
   logic [IW-1:0] idx_q;
   logic [IW-1:0] idx_inc;
   logic [IW-1:0] idx_clamped;

   if ((1 << IW) == DEPTH) begin : g_wrap_pow2
      assign idx_inc = idx_q + 1'b1;
   end else begin : g_wrap_cmp
      assign idx_inc = (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
   end

   assign idx_clamped = (wdata_i > DW'(DEPTH - 1)) ? LAST_IDX : wdata_i[IW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q <= '0;
         for (int i = 0; i < DEPTH; i++) store_q[i] <= '0;
      end else if (idx_wr_i) begin
         idx_q <= idx_clamped;
      end else if (port_wr_i) begin
         store_q[idx_q] <= wdata_i;
         idx_q          <= idx_inc;
      end else if (port_rd_i) begin
         idx_q <= idx_inc;
      end
   end

   assign idx_o       = DW'(idx_q);
   assign port_data_o = store_q[idx_q];

   assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      int'(idx_q) < int'(DEPTH));

   assert_idx_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_wr_i && wdata_i >= DW'(DEPTH)) |=> idx_q == LAST_IDX);

   assert_port_adv_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!idx_wr_i && (port_wr_i || port_rd_i))
         |=> int'(idx_q) == ((int'($past(idx_q)) == int'(DEPTH) - 1) ? 0 : int'($past(idx_q)) + 1));

   assert_port_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!idx_wr_i && port_wr_i) |=> store_q[$past(idx_q)] == $past(wdata_i));
endmodule

// File: rtl/rpw_evt_reg.sv
module rpw_evt_reg #(
   parameter int unsigned NEV = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NEV-1:0] set_i,
   input  logic           ack_wr_i,
   input  logic [NEV-1:0] ack_i,
   output logic [NEV-1:0] pend_o
);
   logic [NEV-1:0] pend_q;
   logic [NEV-1:0] clr;

   assign clr = ack_wr_i ? ack_i : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= (pend_q & ~clr) | set_i;
   end

   assign pend_o = pend_q;

   for (genvar i = 0; i < NEV; i++) begin : g_chk
      assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> pend_q[i]);
      assert_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (ack_wr_i && ack_i[i] && !set_i[i]) |=> !pend_q[i]);
      assert_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (!set_i[i] && !(ack_wr_i && ack_i[i])) |=> $stable(pend_q[i]));
   end
endmodule

// File: rtl/reg_ptr_window.sv
module reg_ptr_window
   import rpw_pkg::*;
#(
   parameter int unsigned AW         = 8,
   parameter int unsigned DW         = RPW_BYTE_W,
   parameter int unsigned BANK_DEPTH = 200,
   parameter int unsigned NUM_HOLD   = 4,
   parameter logic [NUM_HOLD*AW-1:0] HOLD_LIST = {8'h29, 8'h2D, 8'h4F, 8'h7F},
   parameter logic [AW-1:0] EVT_ADDR  = 8'h02,
   parameter logic [AW-1:0] IDX_ADDR  = 8'h60,
   parameter logic [AW-1:0] PORT_ADDR = 8'h61
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          txn_start_i,
   input  logic [AW-1:0] addr_i,
   input  logic          wr_i,
   input  logic [DW-1:0] wr_data_i,
   input  logic          rd_i,
   output logic [DW-1:0] rd_data_o,
   input  logic          rtc_evt_i,
   input  logic          wdt_evt_i
);
   localparam int unsigned NUM_REGS = 1 << AW;
   localparam int unsigned NEV      = RPW_NUM_EVT;

   if (EVT_ADDR == IDX_ADDR || EVT_ADDR == PORT_ADDR || IDX_ADDR == PORT_ADDR) begin : g_bad_map
      $error("reg_ptr_window: special register addresses must differ");
   end
   if (DW <= NEV) begin : g_bad_dw
      $error("reg_ptr_window: DW must exceed the event count");
   end

   acc_kind_e     acc;
   logic [AW-1:0] ptr;
   logic [DW-1:0] idx_val;
   logic [DW-1:0] bank_val;
   logic [NEV-1:0] pend;
   logic [DW-1:0] regs_q [NUM_REGS];
   logic          at_idx, at_port, at_evt;

   always_comb begin
      if (txn_start_i) acc = ACC_IDLE;
      else if (wr_i)   acc = ACC_WRITE;
      else if (rd_i)   acc = ACC_READ;
      else             acc = ACC_IDLE;
   end

   assign at_idx  = (ptr == IDX_ADDR);
   assign at_port = (ptr == PORT_ADDR);
   assign at_evt  = (ptr == EVT_ADDR);

   rpw_ptr_ctrl #(
      .AW(AW), .NUM_HOLD(NUM_HOLD), .HOLD_LIST(HOLD_LIST),
      .IDX_ADDR(IDX_ADDR), .PORT_ADDR(PORT_ADDR)
   ) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load_i(txn_start_i), .addr_i(addr_i),
      .step_i(acc != ACC_IDLE), .ptr_o(ptr)
   );

   rpw_bank_window #(.DW(DW), .DEPTH(BANK_DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .idx_wr_i(acc == ACC_WRITE && at_idx),
      .port_wr_i(acc == ACC_WRITE && at_port),
      .port_rd_i(acc == ACC_READ && at_port),
      .wdata_i(wr_data_i),
      .idx_o(idx_val), .port_data_o(bank_val)
   );

   rpw_evt_reg #(.NEV(NEV)) u_evt (
      .clk(clk), .rst_n(rst_n),
      .set_i({{(NEV-1){wdt_evt_i}}, wdt_evt_i | rtc_evt_i}),
      .ack_wr_i(acc == ACC_WRITE && at_evt),
      .ack_i(wr_data_i[NEV-1:0]),
      .pend_o(pend)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= '0;
      end else if (acc == ACC_WRITE && !at_idx && !at_port) begin
         regs_q[ptr] <= wr_data_i;
      end
   end

   always_comb begin
      if (at_idx)       rd_data_o = idx_val;
      else if (at_port) rd_data_o = bank_val;
      else if (at_evt)  rd_data_o = {regs_q[EVT_ADDR][DW-1:NEV], pend};
      else              rd_data_o = regs_q[ptr];
   end

   assert_plain_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc == ACC_WRITE && !at_idx && !at_port && !at_evt) |=> regs_q[$past(ptr)] == $past(wr_data_i));

   assert_start_wins_R1: assert property (@(posedge clk) disable iff (!rst_n)
      txn_start_i |=> $stable(idx_val));
endmodule

// File: tb/reg_ptr_window_bench.sv
module reg_ptr_window_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       txn_start_i = 1'b0;
   logic [7:0] addr_i = '0;
   logic       wr_i = 1'b0;
   logic [7:0] wr_data_i = '0;
   logic       rd_i = 1'b0;
   logic [7:0] rd_data_o;
   logic       rtc_evt_i = 1'b0;
   logic       wdt_evt_i = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [7:0] m_regs [256];
   logic [7:0] m_bank [200];
   int         m_idx;
   logic [7:0] m_ptr;
   logic [1:0] m_evt;

   reg_ptr_window u_reg_ptr_window (
      .clk(clk), .rst_n(rst_n), .txn_start_i(txn_start_i), .addr_i(addr_i),
      .wr_i(wr_i), .wr_data_i(wr_data_i), .rd_i(rd_i), .rd_data_o(rd_data_o),
      .rtc_evt_i(rtc_evt_i), .wdt_evt_i(wdt_evt_i)
   );

   always #5 clk = ~clk;

   function automatic bit holds(logic [7:0] p);
      return p inside {8'h29, 8'h2D, 8'h4F, 8'h7F, 8'h60, 8'h61};
   endfunction

   function automatic logic [7:0] exp_read();
      if (m_ptr == 8'h60)      return 8'(m_idx);
      else if (m_ptr == 8'h61) return m_bank[m_idx];
      else if (m_ptr == 8'h02) return {m_regs[2][7:2], m_evt};
      else                     return m_regs[m_ptr];
   endfunction

   function automatic string tag_of(logic [7:0] p);
      if (p == 8'h60)      return "R4";
      else if (p == 8'h61) return "R5";
      else if (p == 8'h02) return "R7";
      else if (holds(p))   return "R3";
      else                 return "R2";
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
      end
   endtask

   task automatic start(logic [7:0] a);
      @(negedge clk);
      txn_start_i = 1'b1; addr_i = a;
      m_ptr = a;
      @(posedge clk); #1;
      txn_start_i = 1'b0;
   endtask

   task automatic model_adv();
      if (m_ptr == 8'h61) m_idx = (m_idx == 199) ? 0 : m_idx + 1;
      if (!holds(m_ptr)) m_ptr = m_ptr + 8'd1;
   endtask

   task automatic rd(string tag);
      @(negedge clk);
      rd_i = 1'b1;
      #1;
      chk(tag, rd_data_o, exp_read());
      model_adv();
      @(posedge clk); #1;
      rd_i = 1'b0;
   endtask

   task automatic wr(logic [7:0] d);
      @(negedge clk);
      wr_i = 1'b1; wr_data_i = d;
      if (m_ptr == 8'h60)      m_idx = (d > 8'd199) ? 199 : int'(d);
      else if (m_ptr == 8'h61) m_bank[m_idx] = d;
      else if (m_ptr == 8'h02) begin
         m_evt = m_evt & ~d[1:0];
         m_regs[2] = d;
      end else m_regs[m_ptr] = d;
      if (m_ptr != 8'h60) model_adv();
      @(posedge clk); #1;
      wr_i = 1'b0;
   endtask

   task automatic evt(bit rtc, bit wdt);
      @(negedge clk);
      rtc_evt_i = rtc; wdt_evt_i = wdt;
      m_evt = m_evt | {wdt, wdt | rtc};
      @(posedge clk); #1;
      rtc_evt_i = 1'b0; wdt_evt_i = 1'b0;
   endtask

   function automatic logic [7:0] pick_addr();
      case ($urandom % 12)
         0: return 8'h00;  1: return 8'h02;  2: return 8'h28;
         3: return 8'h29;  4: return 8'h5F;  5: return 8'h60;
         6: return 8'h61;  7: return 8'h7F;  8: return 8'hFE;
         9: return 8'h4F;  default: return 8'($urandom);
      endcase
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20517));
      for (int i = 0; i < 256; i++) m_regs[i] = '0;
      for (int i = 0; i < 200; i++) m_bank[i] = '0;
      m_idx = 0; m_ptr = '0; m_evt = '0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;

      // R9: reset state seen through reads
      #1; chk("R9", rd_data_o, 8'h00);
      start(8'h60); rd("R9");
      start(8'h02); rd("R9");
      start(8'h61); rd("R9");

      // R2: two-byte write from 0x00 lands on 0x00 and 0x01
      start(8'h00); wr(8'hA1); wr(8'hB2);
      start(8'h00); rd("R2"); rd("R2"); rd("R2");
      // R2: wrap 0xFF -> 0x00
      start(8'hFF); wr(8'h5C); wr(8'h3D);
      start(8'hFF); rd("R2"); rd("R2");

      // R3: hold at 0x29, neighbour untouched
      start(8'h29); wr(8'h11); wr(8'h22); rd("R3"); rd("R3");
      start(8'h2A); rd("R3");

      // R4: clamp and pointer hold on index register
      start(8'h60); wr(8'd250); rd("R4"); wr(8'd5); rd("R4");
      wr(8'd199); rd("R4"); wr(8'd200); rd("R4");

      // R5/R6: storage port wraps 199 -> 0, reads see pre-advance byte
      start(8'h60); wr(8'd198);
      start(8'h61); wr(8'h71); wr(8'h72); wr(8'h73);
      start(8'h60); rd("R5");
      wr(8'd198);
      start(8'h61); rd("R6"); rd("R6"); rd("R6"); rd("R6");
      start(8'h60); rd("R5");

      // R8/R7: event flags
      evt(1'b0, 1'b1); start(8'h02); rd("R8");
      start(8'h02); wr(8'h01); start(8'h02); rd("R7");
      start(8'h02); wr(8'h00); start(8'h02); rd("R7");
      start(8'h02); wr(8'h02); start(8'h02); rd("R7");
      evt(1'b1, 1'b0); start(8'h02); rd("R8");
      start(8'h02); wr(8'hFC); start(8'h02); rd("R7");

      // R1: restart mid-burst reloads pointer
      start(8'h10); wr(8'h44); wr(8'h55);
      start(8'h10); rd("R1");
      start(8'h00); rd("R1");

      // Random mix checked against the model
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = int'($urandom % 100);
         if (r < 12)      start(pick_addr());
         else if (r < 55) rd(tag_of(m_ptr));
         else if (r < 96) wr(8'($urandom));
         else             evt(1'($urandom), 1'($urandom));
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule